// File: doc/BRIEF.md
# VSYNC-Counted Panel Power-Up Sequencer

This block brings a display panel out of power-off in a fixed order once its supply has settled. When the supply-good flag rises, the block first holds the panel's global reset line low for a timed interval. It then releases reset and waits through a quiet window in which the video timing must stay still. After that window it counts frame sync pulses and turns on four stages in order: the analog rail, the charge-pump clock, the panel control and data drivers, and the PWM boost control.

Each stage is keyed to a number of counted frame sync pulses, not to elapsed time. The reset length and the quiet window are set in microseconds and converted to clock cycles from the clock frequency parameter. If the supply flag drops at any point, every output returns to its off state and the sequence starts again from the reset pulse.

Top module: `pwrup_sequencer`

## Requirements
- R1: During synchronous reset (`rst` high), and on the first cycle after it, every enable output is 0 and `panel_rst_n_o` is 0.
- R2: While `supply_ok_i` is 0, `panel_rst_n_o` stays 0 and every enable output stays 0.
- R3: After `supply_ok_i` rises, `panel_rst_n_o` stays low for at least RST_CYC clock cycles and goes high no later than RST_CYC+2 cycles. RST_CYC is the reset time converted to cycles and rounded up.
- R4: For QUIET_CYC cycles after reset release, falling edges of `vsync_n_i` are not counted. A falling edge inside this window restarts the window. No enable asserts before the window has ended.
- R5: `vsync_n_i` is active low. It is synchronised, and each high-to-low transition counts exactly once, however long the input then stays low.
- R6: `avdd_en_o` goes to 1 within four cycles of the 2nd counted falling edge, and not before that edge.
- R7: `cpclk_en_o` goes to 1 within four cycles of the 3rd counted falling edge, and not before that edge.
- R8: `panel_en_o` goes to 1 within four cycles of the 9th counted falling edge, and stays 0 through the 8th.
- R9: `pwm_en_o` goes to 1 within four cycles of the 11th counted falling edge. Further falling edges change no output.
- R10: The enables are nested: `pwm_en_o` implies `panel_en_o`, which implies `cpclk_en_o`, which implies `avdd_en_o`. Any enable being 1 implies `panel_rst_n_o` is 1.
- R11: One cycle after `supply_ok_i` is seen low, every enable and `panel_rst_n_o` are 0. When the supply returns, the sequence restarts from R3 with the pulse count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply stable flag, synchronous to clk |
| vsync_n_i | input | 1 | Frame sync, active low, may be asynchronous |
| panel_rst_n_o | output | 1 | Panel global reset, active low |
| avdd_en_o | output | 1 | Analog rail enable |
| cpclk_en_o | output | 1 | Charge-pump clock enable |
| panel_en_o | output | 1 | Panel control and data output enable |
| pwm_en_o | output | 1 | PWM boost control enable |

## Verification
The assertions assume that `supply_ok_i` is already synchronous to `clk`. They also assume that frame sync pulses, high and low phases alike, last at least one full clock period, so that the synchroniser catches every transition. The bench drives both inputs on the falling clock edge. It holds each sync level for at least one whole cycle and leaves six idle cycles after every pulse. That gap covers the synchroniser and the registered outputs before anything is sampled. The quiet-window test places one pulse early in the window and another just after the point where an unrestarted window would have closed.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        S_OFF,
        S_RESET,
        S_QUIET,
        S_COUNT
    } seq_state_e;

    localparam int NUM_STAGES = 4;
    localparam int CNT_W      = 4;

    // Pulse count at which each stage turns on; index 0 = analog rail,
    // 1 = charge-pump clock, 2 = panel drivers, 3 = PWM boost.
    localparam logic [CNT_W-1:0] STAGE_AT [NUM_STAGES] = '{4'd2, 4'd3, 4'd9, 4'd11};

    // Convert microseconds to clock cycles, rounding up, never below 1.
    function automatic int us_to_cycles(input int clk_khz, input int usec);
        int c;
        c = (clk_khz * usec + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/pwrseq_vsync_edge.sv
module pwrseq_vsync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic vsync_n_i,
    output logic fall_o
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[LAST-1:0], vsync_n_i};
        end
    end

    assign fall_o = chain_q[LAST] & ~chain_q[LAST-1];

    // R5: a detected edge never lasts more than one cycle
    p_single_fall_r5: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic done_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (!done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LAST);

    // R3/R4: once expired the timer stays expired until cleared
    p_done_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && !clr_i) |=> done_o);

endmodule

// File: rtl/pwrup_sequencer.sv
module pwrup_sequencer
    import pwrseq_pkg::*;
#(
    parameter int CLK_KHZ     = 27000,
    parameter int RST_US      = 170,
    parameter int QUIET_US    = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic vsync_n_i,
    output logic panel_rst_n_o,
    output logic avdd_en_o,
    output logic cpclk_en_o,
    output logic panel_en_o,
    output logic pwm_en_o
);
    localparam int RST_CYC   = us_to_cycles(CLK_KHZ, RST_US);
    localparam int QUIET_CYC = us_to_cycles(CLK_KHZ, QUIET_US);
    localparam logic [CNT_W-1:0] CNT_MAX = STAGE_AT[NUM_STAGES-1];

    seq_state_e             state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic [NUM_STAGES-1:0]  en_q;
    logic                   rst_n_q;
    logic                   fall;
    logic                   rst_done, quiet_done;

    pwrseq_vsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .vsync_n_i(vsync_n_i),
        .fall_o   (fall)
    );

    pwrseq_timer #(.LIMIT(RST_CYC)) u_rst_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr_i (state_q != S_RESET),
        .done_o(rst_done)
    );

    pwrseq_timer #(.LIMIT(QUIET_CYC)) u_quiet_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr_i ((state_q != S_QUIET) || fall),
        .done_o(quiet_done)
    );

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_OFF:   if (supply_ok_i) state_d = S_RESET;
            S_RESET: if (rst_done)    state_d = S_QUIET;
            S_QUIET: if (quiet_done && !fall) state_d = S_COUNT;
            S_COUNT: if (fall && (cnt_q < CNT_MAX)) cnt_d = cnt_q + 1'b1;
            default: state_d = S_OFF;
        endcase
        if (!supply_ok_i) begin
            state_d = S_OFF;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_OFF;
            cnt_q   <= '0;
            rst_n_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rst_n_q <= (state_d == S_QUIET) || (state_d == S_COUNT);
        end
    end

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[i] <= 1'b0;
            end else begin
                en_q[i] <= supply_ok_i && (state_q == S_COUNT) && (cnt_q >= STAGE_AT[i]);
            end
        end
    end

    assign panel_rst_n_o = rst_n_q;
    assign avdd_en_o     = en_q[0];
    assign cpclk_en_o    = en_q[1];
    assign panel_en_o    = en_q[2];
    assign pwm_en_o      = en_q[3];

    // R10: stages are nested in turn-on order
    p_pwm_needs_panel_r10: assert property (@(posedge clk) disable iff (rst)
        pwm_en_o |-> panel_en_o);
    p_panel_needs_cp_r10: assert property (@(posedge clk) disable iff (rst)
        panel_en_o |-> cpclk_en_o);
    p_cp_needs_avdd_r10: assert property (@(posedge clk) disable iff (rst)
        cpclk_en_o |-> avdd_en_o);
    p_en_after_release_r10: assert property (@(posedge clk) disable iff (rst)
        (|en_q) |-> panel_rst_n_o);
    // R11: supply loss drops everything on the next cycle
    p_supply_loss_r11: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_i |=> (!panel_rst_n_o && en_q == '0));
    // R4: nothing turns on outside the counting phase
    p_no_enable_early_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_COUNT) |-> (en_q == '0));
    // R9: the pulse count moves by one at most and never past the last stage
    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));
    p_count_cap_r9: assert property (@(posedge clk) disable iff (rst)
        (fall && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || !$past(supply_ok_i)));

endmodule

// File: tb/sim_pwrup_sequencer.sv
module sim_pwrup_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 20;
    localparam int QUIET_CYC  = 40;

    // [11:4] low width in cycles, [3:0] expected {pwm,panel,cp,avdd}
    localparam logic [11:0] PULSE_TBL [12] = '{
        {8'd1,  4'b0000}, {8'd3,  4'b0001}, {8'd20, 4'b0011}, {8'd1,  4'b0011},
        {8'd2,  4'b0011}, {8'd5,  4'b0011}, {8'd1,  4'b0011}, {8'd30, 4'b0011},
        {8'd1,  4'b0111}, {8'd4,  4'b0111}, {8'd2,  4'b1111}, {8'd9,  4'b1111}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic vsync_n = 1'b1;
    logic panel_rst_n, avdd_en, cpclk_en, panel_en, pwm_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrup_sequencer #(
        .CLK_KHZ (1000),
        .RST_US  (RST_CYC),
        .QUIET_US(QUIET_CYC)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .supply_ok_i  (supply_ok),
        .vsync_n_i    (vsync_n),
        .panel_rst_n_o(panel_rst_n),
        .avdd_en_o    (avdd_en),
        .cpclk_en_o   (cpclk_en),
        .panel_en_o   (panel_en),
        .pwm_en_o     (pwm_en)
    );

    function automatic logic [4:0] outs();
        return {panel_rst_n, pwm_en, panel_en, cpclk_en, avdd_en};
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        n_tests++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs {rst_n,pwm,panel,cp,avdd} got %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int width);
        vsync_n = 1'b0;
        idle(width);
        vsync_n = 1'b1;
        idle(6);
    endtask

    task automatic power_up_and_settle();
        supply_ok = 1'b1;
        for (int i = 0; i < 200 && !panel_rst_n; i++) @(negedge clk);
        idle(QUIET_CYC + 20);
    endtask

    initial begin
        int len;
        idle(3);
        check("R1", 5'b00000);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 5'b00000);

        // R2: no supply, sync activity has no effect
        pulse(2); pulse(2); pulse(2);
        check("R2", 5'b00000);

        // R3: reset pulse length
        supply_ok = 1'b1;
        len = 0;
        for (int i = 0; i < 200 && !panel_rst_n; i++) begin
            @(negedge clk);
            len++;
        end
        n_tests++;
        if (len < RST_CYC || len > RST_CYC + 2) begin
            n_fail++;
            $display("FAIL R3: reset low for %0d cycles expected %0d..%0d", len, RST_CYC, RST_CYC + 2);
        end
        check("R3", 5'b10000);

        // R4: pulses inside the quiet window, second one after unrestarted end
        idle(7);
        pulse(1);
        idle(45 - 7 - 1 - 6 - 3);
        pulse(1);
        check("R4", 5'b10000);
        idle(QUIET_CYC + 20);
        pulse(1);
        check("R4", 5'b10000);
        pulse(1);
        check("R6", 5'b10001);

        // R11: supply loss clears everything next cycle
        supply_ok = 1'b0;
        @(negedge clk);
        check("R11", 5'b00000);
        idle(5);

        // R11 restart, then the table walks R5..R9
        power_up_and_settle();
        check("R11", 5'b10000);
        for (int k = 0; k < 12; k++) begin
            pulse(int'(PULSE_TBL[k][11:4]));
            check($sformatf("R5-table pulse %0d (R6 R7 R8 R9)", k + 1), {1'b1, PULSE_TBL[k][3:0]});
        end
        idle(10);
        check("R9", 5'b11111);

        supply_ok = 1'b0;
        @(negedge clk);
        check("R11", 5'b00000);
        pulse(3);
        check("R2", 5'b00000);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule